// File: doc/BRIEF.md
# Strap-Addressed SPI Slave Receiver with Hold

This block is the serial front end of a multi-channel setting device. It takes mode 0 SPI traffic on four pins: an active-low select, a serial clock, a data input and a data output. All four are oversampled by a faster system clock. The first byte of every frame is an address byte. It is compared with a fixed four-bit device identifier, two zero bits and a two-bit board strap, so up to four such devices can share one bus. Only a frame whose address byte matches is passed on. Every later byte goes to a command executor as a one-cycle valid strobe. Each accepted clock rise after the address is also reported as a step event carrying the data-in level, which the executor can use for up/down nudging.

The executor supplies reply bytes. The block loads one at the start of each byte slot and shifts it out most significant bit first, changing the output after falling clock edges. A hold input freezes a frame in mid-byte. While held, the output is floated and clock and data activity is ignored. When hold is released, the transfer picks up at the bit where it stopped. The executor is told when a frame starts and when select rises after an addressed frame, because that rise is the moment at which it commits stored settings.

Top module: `spi_strap_slave`

## Requirements
- R1: After reset, `sdo_oe_o`, `rx_valid_o`, `frame_start_o`, `frame_end_o` and `step_o` are all low.
- R2: Data-in is sampled on each rising serial-clock edge, most significant bit first. Eight rises after the address byte give one `rx_valid_o` pulse, with the assembled byte on `rx_byte_o`.
- R3: The address byte must equal bits [7:4]=0101, bits [3:2]=00 and bits [1:0]=`strap_i`. On a mismatch, the rest of the frame produces no byte, step, start or end event, and `sdo_oe_o` stays low.
- R4: `frame_start_o` pulses once when the eighth bit of a matching address byte is received.
- R5: At the first falling clock edge after each byte boundary of an addressed frame, `tx_byte_i` is loaded if `tx_ready_i` is high. Its bits then appear on `sdo_o` MSB first, one per falling edge, with `sdo_oe_o` high. If `tx_ready_i` is low, `sdo_oe_o` stays low for that byte. `sdo_oe_o` is always low during the address byte.
- R6: Each accepted rising edge after a matching address byte gives one `step_o` pulse. `step_up_o` equals the data-in bit sampled at that edge.
- R7: If hold goes low while the serial clock is low, `sdo_oe_o` drops, and clock edges and data-in produce no step, byte or shift until hold returns high.
- R8: When hold returns high with the serial clock low, reception and reply shifting continue from the same bit position. No bit is lost or repeated.
- R9: A hold change that occurs while the serial clock is high has no effect until the clock is next low.
- R10: With select high the block is idle. `sdo_oe_o` is low, clock edges are ignored and a partial byte is discarded. A new frame needs a high-to-low select edge. The select rise that ends an addressed frame gives one `frame_end_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause request, active low |
| strap_i | input | STRAP_W | Board address strap compared with address byte bits [1:0] |
| tx_ready_i | input | 1 | Executor has a reply byte for the coming byte slot |
| tx_byte_i | input | BYTE_W | Reply byte |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for the data-out pad; low means floating |
| rx_valid_o | output | 1 | One-cycle strobe: a byte after the address was received |
| rx_byte_o | output | BYTE_W | Received byte |
| frame_start_o | output | 1 | One-cycle strobe: address byte matched |
| frame_end_o | output | 1 | One-cycle strobe: select rose after an addressed frame |
| step_o | output | 1 | One-cycle strobe per accepted clock rise after the address |
| step_up_o | output | 1 | Data-in level at the last step |

## Verification
The hardest case to reach is a pause that is requested while the serial clock is high. The pause must not begin at that moment. It must begin when the clock next falls, and that same fall must still advance the reply shifter. The bench raises the clock, drops hold, checks that the output enable is still high, then lowers the clock. It checks that the output floats, toggles clock and data while paused, and releases hold. The remaining reply bits and the received byte must then line up exactly. A second directed frame pauses with the clock low after three bits, to confirm that the bit position is kept.

// File: rtl/spss_pkg.sv
`timescale 1ns/1ps
package spss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // select high
    ST_ADDR = 2'd1,  // collecting the address byte
    ST_LIVE = 2'd2,  // addressed: bytes go to the executor
    ST_SKIP = 2'd3   // address mismatch: rest of frame dropped
  } spss_state_e;

  // Bit order of the synchronised pin bundle
  localparam int PIN_SDI  = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_HOLD = 2;
  localparam int PIN_CS   = 3;
  localparam int PIN_W    = 4;
endpackage

// File: rtl/spss_sync.sv
`timescale 1ns/1ps
module spss_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spss_gate.sv
`timescale 1ns/1ps
module spss_gate (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic held_o
);
  logic sck_q, cs_q, held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      held_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_n_i;
      // pause state may only change while the serial clock is low
      if (cs_n_i)      held_q <= 1'b0;
      else if (!sck_i) held_q <= !hold_n_i;
    end
  end

  assign rise_o    = sck_i & ~sck_q & ~held_q & ~cs_n_i;
  assign fall_o    = ~sck_i & sck_q & ~held_q & ~cs_n_i;
  assign cs_fall_o = ~cs_n_i & cs_q;
  assign cs_rise_o = cs_n_i & ~cs_q;
  assign held_o    = held_q;

  // R9: a hold change with SCK high is deferred
  a_r9_hold_waits_sck_low: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_i && sck_i) |=> $stable(held_q));
endmodule

// File: rtl/spss_shift.sv
`timescale 1ns/1ps
module spss_shift
  import spss_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              cs_n_i,
  input  logic              held_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              tx_ready_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              step_o,
  output logic              step_up_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int              CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  spss_state_e       st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, rx_next;
  logic              tx_live_q, last_bit, addr_hit;

  assign rx_next  = {rx_q[BYTE_W-2:0], sdi_i};
  assign last_bit = (cnt_q == LAST);
  assign addr_hit = (rx_next == addr_i);
  assign sdo_o    = tx_q[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      cnt_q         <= '0;
      rx_q          <= '0;
      tx_q          <= '0;
      tx_live_q     <= 1'b0;
      rx_valid_o    <= 1'b0;
      rx_byte_o     <= '0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      step_o        <= 1'b0;
      step_up_o     <= 1'b0;
      sdo_oe_o      <= 1'b0;
    end else begin
      rx_valid_o    <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      step_o        <= 1'b0;
      sdo_oe_o      <= !cs_n_i && tx_live_q && !held_i;
      if (cs_n_i) begin
        st_q        <= ST_IDLE;
        cnt_q       <= '0;
        tx_live_q   <= 1'b0;
        frame_end_o <= cs_rise_i && (st_q == ST_LIVE);
      end else if (cs_fall_i) begin
        st_q      <= ST_ADDR;
        cnt_q     <= '0;
        tx_live_q <= 1'b0;
      end else begin
        if (rise_i && (st_q == ST_ADDR || st_q == ST_LIVE)) begin
          rx_q  <= rx_next;
          cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
          if (st_q == ST_LIVE) begin
            step_o    <= 1'b1;
            step_up_o <= sdi_i;
            if (last_bit) begin
              rx_valid_o <= 1'b1;
              rx_byte_o  <= rx_next;
            end
          end else if (last_bit) begin
            st_q          <= addr_hit ? ST_LIVE : ST_SKIP;
            frame_start_o <= addr_hit;
          end
        end
        if (fall_i && st_q == ST_LIVE) begin
          if (cnt_q == '0) begin
            tx_live_q <= tx_ready_i;
            tx_q      <= tx_byte_i;
          end else begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R10: select high forces idle and a floating output
  a_r10_idle_on_deselect: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> (!sdo_oe_o && st_q == ST_IDLE));
  // R7: paused means floating output
  a_r7_float_when_held: assert property (@(posedge clk) disable iff (rst)
    held_i |=> !sdo_oe_o);
  // R8: bit position frozen across a pause
  a_r8_hold_keeps_position: assert property (@(posedge clk) disable iff (rst)
    (held_i && $past(held_i)) |-> $stable(cnt_q));
  // R6: step events only come from an addressed frame
  a_r6_step_only_live: assert property (@(posedge clk) disable iff (rst)
    step_o |-> ($past(st_q) == ST_LIVE));
  // R3: a rejected frame produces no start and no bytes
  a_r3_skip_is_silent: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SKIP) |=> (!frame_start_o && !rx_valid_o));
endmodule

// File: rtl/spi_strap_slave.sv
`timescale 1ns/1ps
module spi_strap_slave
  import spss_pkg::*;
#(
  parameter int          BYTE_W      = 8,
  parameter int          STRAP_W     = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_ID      = 4'b0101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               hold_n_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               tx_ready_i,
  input  logic [BYTE_W-1:0]  tx_byte_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic               rx_valid_o,
  output logic [BYTE_W-1:0]  rx_byte_o,
  output logic               frame_start_o,
  output logic               frame_end_o,
  output logic               step_o,
  output logic               step_up_o
);
  localparam int PAD_W = BYTE_W - 4 - STRAP_W;
  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1 << PIN_CS) | PIN_W'(1 << PIN_HOLD);

  logic [PIN_W-1:0]  pins_raw, pins_s;
  logic [BYTE_W-1:0] addr_exp;
  logic              rise, fall, cs_fall, cs_rise, held;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SDI]  = sdi_i;
    pins_raw[PIN_SCK]  = sck_i;
    pins_raw[PIN_HOLD] = hold_n_i;
    pins_raw[PIN_CS]   = cs_n_i;
  end

  assign addr_exp = {DEV_ID, {PAD_W{1'b0}}, strap_i};

  spss_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk), .rst (rst), .d_i (pins_raw), .q_o (pins_s)
  );

  spss_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .cs_n_i    (pins_s[PIN_CS]),
    .sck_i     (pins_s[PIN_SCK]),
    .hold_n_i  (pins_s[PIN_HOLD]),
    .rise_o    (rise),
    .fall_o    (fall),
    .cs_fall_o (cs_fall),
    .cs_rise_o (cs_rise),
    .held_o    (held)
  );

  spss_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk           (clk),
    .rst           (rst),
    .sdi_i         (pins_s[PIN_SDI]),
    .rise_i        (rise),
    .fall_i        (fall),
    .cs_fall_i     (cs_fall),
    .cs_rise_i     (cs_rise),
    .cs_n_i        (pins_s[PIN_CS]),
    .held_i        (held),
    .addr_i        (addr_exp),
    .tx_ready_i    (tx_ready_i),
    .tx_byte_i     (tx_byte_i),
    .rx_valid_o    (rx_valid_o),
    .rx_byte_o     (rx_byte_o),
    .frame_start_o (frame_start_o),
    .frame_end_o   (frame_end_o),
    .step_o        (step_o),
    .step_up_o     (step_up_o),
    .sdo_o         (sdo_o),
    .sdo_oe_o      (sdo_oe_o)
  );
endmodule

// File: tb/spi_strap_slave_tb.sv
`timescale 1ns/1ps
module spi_strap_slave_tb;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, cs_n, sck, sdi, hold_n, tx_ready;
  logic [1:0] strap;
  logic [7:0] tx_byte;
  logic       sdo, sdo_oe, rx_valid, frame_start, frame_end, step, step_up;
  logic [7:0] rx_byte;

  spi_strap_slave u_dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi), .hold_n_i(hold_n),
    .strap_i(strap), .tx_ready_i(tx_ready), .tx_byte_i(tx_byte),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .frame_start_o(frame_start), .frame_end_o(frame_end), .step_o(step), .step_up_o(step_up)
  );

  int errors = 0;
  int checks = 0;
  int n_start = 0, n_end = 0, n_byte = 0, n_step = 0, n_up = 0;
  logic [7:0] last_byte = 8'h00;

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_start) n_start++;
      if (frame_end)   n_end++;
      if (rx_valid) begin n_byte++; last_byte = rx_byte; end
      if (step) begin n_step++; if (step_up) n_up++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic so, output logic oe);
    sdi = b;
    wait_clk(HALF);
    so = sdo; oe = sdo_oe;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] got, output logic [7:0] oes);
    for (int i = 7; i >= 0; i--) send_bit(b[i], got[i], oes[i]);
  endtask

  task automatic end_frame();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  // {strap[1:0], addr[7:0], data[7:0], reply[7:0], reply_ready}
  localparam logic [26:0] VEC [7] = '{
    {2'b00, 8'h50, 8'hA5, 8'h3C, 1'b1},
    {2'b11, 8'h53, 8'h00, 8'hFF, 1'b1},
    {2'b10, 8'h52, 8'hFF, 8'h81, 1'b0},
    {2'b01, 8'h52, 8'h5A, 8'h77, 1'b1},
    {2'b00, 8'h70, 8'hC3, 8'h11, 1'b1},
    {2'b00, 8'h54, 8'h0F, 8'h22, 1'b1},
    {2'b01, 8'h51, 8'h96, 8'h69, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] g0, g1, o0, o1, got, oes;
    logic       so, oe;
    int s_start, s_end, s_byte, s_step, s_up;
    rst = 1'b1; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; hold_n = 1'b1;
    strap = 2'b00; tx_ready = 1'b0; tx_byte = 8'h00;
    wait_clk(6);
    rst = 1'b0;
    wait_clk(6);
    // R1: reset state
    chk(!sdo_oe, "R1 oe after reset", int'(sdo_oe), 0);
    chk(!rx_valid && !frame_start && !frame_end && !step, "R1 strobes after reset",
        int'({rx_valid, frame_start, frame_end, step}), 0);
    chk(n_start + n_end + n_byte + n_step == 0, "R1 no events", n_start + n_end + n_byte + n_step, 0);

    // Table-driven frames: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < 7; v++) begin
      logic [7:0] addr, data, reply;
      logic       rv, match;
      strap = VEC[v][26:25]; addr = VEC[v][24:17]; data = VEC[v][16:9];
      reply = VEC[v][8:1];   rv = VEC[v][0];
      tx_ready = rv; tx_byte = reply;
      match = (addr == {4'b0101, 2'b00, strap});
      wait_clk(4);
      s_start = n_start; s_end = n_end; s_byte = n_byte; s_step = n_step; s_up = n_up;
      cs_n = 1'b0;
      wait_clk(HALF);
      send_byte(addr, g0, o0);
      send_byte(data, g1, o1);
      end_frame();
      chk((n_byte - s_byte) == int'(match), "R3 byte count", n_byte - s_byte, int'(match));
      if (match) chk(last_byte == data, "R2 received byte", int'(last_byte), int'(data));
      chk((n_start - s_start) == int'(match), "R4 frame start", n_start - s_start, int'(match));
      chk((n_end - s_end) == int'(match), "R10 frame end", n_end - s_end, int'(match));
      chk((n_step - s_step) == (match ? 8 : 0), "R6 step count", n_step - s_step, match ? 8 : 0);
      chk((n_up - s_up) == (match ? $countones(data) : 0), "R6 step direction",
          n_up - s_up, match ? $countones(data) : 0);
      chk(o0 == 8'h00, "R5 oe low in address byte", int'(o0), 0);
      chk(o1 == ((match && rv) ? 8'hFF : 8'h00), "R5 oe in data byte", int'(o1),
          (match && rv) ? 8'hFF : 8'h00);
      if (match && rv) chk(g1 == reply, "R5 reply bits", int'(g1), int'(reply));
    end

    // R7 / R8: pause with SCK low after three bits
    strap = 2'b10; tx_ready = 1'b1; tx_byte = 8'h5A;
    wait_clk(4);
    s_byte = n_byte; s_step = n_step;
    cs_n = 1'b0; wait_clk(HALF);
    send_byte(8'h52, g0, o0);
    for (int i = 7; i >= 5; i--) send_bit(1'((8'hC3 >> i) & 1), got[i], oes[i]);
    wait_clk(HALF);
    hold_n = 1'b0;
    wait_clk(2 * HALF);
    chk(!sdo_oe, "R7 output floats in pause", int'(sdo_oe), 0);
    for (int k = 0; k < 3; k++) begin
      sdi = ~sdi; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    chk((n_step - s_step) == 3, "R7 edges ignored in pause", n_step - s_step, 3);
    hold_n = 1'b1;
    wait_clk(2 * HALF);
    chk(sdo_oe, "R8 output returns after pause", int'(sdo_oe), 1);
    for (int i = 4; i >= 0; i--) send_bit(1'((8'hC3 >> i) & 1), got[i], oes[i]);
    end_frame();
    chk((n_byte - s_byte) == 1 && last_byte == 8'hC3, "R8 byte across pause", int'(last_byte), 8'hC3);
    chk(got == 8'h5A, "R8 reply across pause", int'(got), 8'h5A);

    // R9: hold dropped while SCK high takes effect only at the next low
    tx_byte = 8'hA5;
    wait_clk(4);
    s_byte = n_byte; s_step = n_step;
    cs_n = 1'b0; wait_clk(HALF);
    send_byte(8'h52, g0, o0);
    send_bit(1'b0, got[7], oes[7]);
    send_bit(1'b0, got[6], oes[6]);
    sdi = 1'b1; wait_clk(HALF);
    got[5] = sdo;
    sck = 1'b1; wait_clk(2);
    hold_n = 1'b0;
    wait_clk(HALF + 2);
    chk(sdo_oe, "R9 no pause while SCK high", int'(sdo_oe), 1);
    sck = 1'b0;
    wait_clk(2 * HALF);
    chk(!sdo_oe, "R9 pause once SCK low", int'(sdo_oe), 0);
    for (int k = 0; k < 2; k++) begin
      sdi = ~sdi; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    hold_n = 1'b1;
    wait_clk(2 * HALF);
    for (int i = 4; i >= 0; i--) send_bit(1'((8'h3C >> i) & 1), got[i], oes[i]);
    end_frame();
    chk((n_step - s_step) == 8, "R9 step count", n_step - s_step, 8);
    chk(last_byte == 8'h3C && (n_byte - s_byte) == 1, "R9 received byte", int'(last_byte), 8'h3C);
    chk(got == 8'hA5, "R9 reply bits", int'(got), 8'hA5);

    // R10: abort mid-byte, then idle clocks, then a clean frame
    strap = 2'b00; tx_byte = 8'h00;
    wait_clk(4);
    s_byte = n_byte; s_end = n_end;
    cs_n = 1'b0; wait_clk(HALF);
    send_byte(8'h50, g0, o0);
    for (int i = 0; i < 3; i++) send_bit(1'b1, so, oe);
    end_frame();
    chk((n_end - s_end) == 1, "R10 end after addressed abort", n_end - s_end, 1);
    chk((n_byte - s_byte) == 0, "R10 partial byte dropped", n_byte - s_byte, 0);
    chk(!sdo_oe, "R10 oe low when deselected", int'(sdo_oe), 0);
    s_step = n_step;
    for (int k = 0; k < 4; k++) begin
      sdi = 1'b1; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    chk((n_step - s_step) == 0, "R10 clocks ignored while idle", n_step - s_step, 0);
    s_byte = n_byte;
    cs_n = 1'b0; wait_clk(HALF);
    send_byte(8'h50, g0, o0);
    send_byte(8'h81, g1, o1);
    end_frame();
    chk((n_byte - s_byte) == 1 && last_byte == 8'h81, "R10 fresh frame after abort",
        int'(last_byte), 8'h81);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule